// File: doc/BRIEF.md
# Address Table Violation Capture

This block sits beside a switch's address table and catches the exceptional events that the table raises: an entry aging out, a frame from a port that is not a member, a lookup that found no entry, and an insert that found the table full. Each event arrives as a one-cycle strobe. Side information travels with it: the source port, the MAC address, the database number and the port vector. The block keeps one such event at a time and raises a level interrupt while it holds one.

Software collects the event through the same operation, data and MAC words that it uses for ordinary table commands. It writes the operation word with the busy bit set and the get-and-clear opcode. Busy then reads high for exactly one cycle. After that, the three words hold the captured event and the block is free for the next one. In the data word, the 4-bit field that normally carries an entry state carries the source port of the offending frame instead.

Top module: `vcap_top`

## Requirements
- R1: After reset the interrupt is low and the operation, data and MAC words all read zero.
- R2: A strobe that arrives while nothing is held is captured at the next clock edge. The interrupt then stays high until a get-and-clear completes.
- R3: Only one event is held at a time. A strobe that arrives while an event is held is dropped and sets a sticky overflow indication. A get-and-clear reports that indication in operation bit 11 and clears it.
- R4: Strobes in the same cycle are resolved by priority: table full, then miss, then membership, then age-out. Only the winner is kept, and the losers count as dropped (R3). The flags sit in the operation word as full bit 4, miss bit 5, membership bit 6 and age-out bit 7, with at most one flag set.
- R5: A write of the operation word with bit 15 set and opcode 3'b111 in bits 14:12 starts get-and-clear. Bit 15 (busy) reads high for the one following cycle and then low. From that point the interrupt is low and bits 14:12 read 3'b111.
- R6: After get-and-clear, the data word carries the source port in bits 3:0 and the port vector from bit 4 upward. The MAC word carries the full 48-bit address.
- R7: After get-and-clear, the 6-bit database number is split across the operation word: bits 3:0 of the number in bits 3:0, and bits 5:4 of the number in bits 9:8.
- R8: A get-and-clear with nothing held returns all flags, database, data and MAC fields as zero, and the interrupt stays low.
- R9: A write without bit 15 set, or with another opcode, has no effect. Busy stays low, the interrupt keeps its level, and all three report words keep their values.
- R10: A strobe that arrives in the cycle where a get-and-clear of a held event completes is dropped and sets overflow. The next get-and-clear then reports overflow with all flags zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_full | input | 1 | Table-full event strobe |
| ev_miss | input | 1 | Lookup-miss event strobe |
| ev_member | input | 1 | Membership-violation event strobe |
| ev_age | input | 1 | Age-out event strobe |
| ev_port | input | 4 | Source port of the event |
| ev_mac | input | 48 | MAC address of the event |
| ev_db | input | 6 | Database number of the event |
| ev_pvec | input | NPORT | Port vector of the event |
| op_wr | input | 1 | Write strobe for the operation word |
| op_wdata | input | 16 | Operation word write data |
| irq | output | 1 | Level interrupt, high while an event is held |
| op_rdata | output | 16 | Operation word: busy, opcode, overflow, flags, database number |
| data_rdata | output | 16 | Data word: source port and port vector |
| mac_rdata | output | 48 | MAC word |

## Verification
On every cycle, the assertions check the following:
- busy lasts exactly one cycle;
- an idle block always captures a strobe;
- the interrupt holds until a get-and-clear;
- a completed get-and-clear of a held event leaves the interrupt low;
- at most one flag is set;
- overflow stays set until collected;
- the report words never move outside a get-and-clear.

Some behaviour only the bench's scenarios can show. This covers which strobe wins a tie, and where the port, port vector, MAC and split database bits land. It also covers dropping a strobe that meets a completing get-and-clear, the all-zero result of an empty get-and-clear, and the fact that malformed writes are ignored.

// File: rtl/vcap_pkg.sv
// Package: shared constants for the violation capture block.
// Assumes the data word state field is 4 bits and the database number is 6 bits.
package vcap_pkg;
    localparam int PID_W    = 4;   // source port id width (state field)
    localparam int DB_W     = 6;   // database number width
    localparam int DB_LO_W  = 4;   // database bits placed in op[3:0]
    localparam int DB_HI_W  = DB_W - DB_LO_W;
    localparam int NKIND    = 4;   // number of violation kinds
    localparam int OPC_W    = 3;
    localparam logic [OPC_W-1:0] OPC_GETCLR = 3'b111;

    // Index of each kind; lower index wins a tie.
    typedef enum logic [1:0] {
        K_FULL   = 2'd0,
        K_MISS   = 2'd1,
        K_MEMBER = 2'd2,
        K_AGE    = 2'd3
    } kind_e;
endpackage

// File: rtl/vcap_prio.sv
// Module: fixed-priority picker. The lowest set request index wins.
// Also flags when more than one request is set, so that losers can be counted as dropped.
module vcap_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win,
    output logic         multi
);
    // Purpose: one-hot winner, lowest index first.
    always_comb begin
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) win = N'(1) << i;
        end
    end

    // Purpose: detect more than one simultaneous request.
    always_comb begin
        multi = (req & (req - N'(1))) != '0;
    end
endmodule

// File: rtl/vcap_hold.sv
// Module: single-entry capture of one violation, with a sticky overflow bit.
// Assumes strobes last one cycle. The clr pulse marks the edge where software
// collects the held entry.
module vcap_hold
    import vcap_pkg::*;
#(
    parameter int NPORT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NKIND-1:0]  strobe,
    input  logic [PID_W-1:0]  in_port,
    input  logic [47:0]       in_mac,
    input  logic [DB_W-1:0]   in_db,
    input  logic [NPORT-1:0]  in_pvec,
    input  logic              clr,
    output logic              pending,
    output logic              ovf,
    output logic [NKIND-1:0]  cap_flags,
    output logic [PID_W-1:0]  cap_port,
    output logic [47:0]       cap_mac,
    output logic [DB_W-1:0]   cap_db,
    output logic [NPORT-1:0]  cap_pvec
);
    logic [NKIND-1:0] win;
    logic             multi;
    logic             any_ev;
    logic             take;
    logic             drop;

    vcap_prio #(.N(NKIND)) u_prio (
        .req   (strobe),
        .win   (win),
        .multi (multi)
    );

    // Purpose: decide whether this cycle's strobes are captured or dropped.
    always_comb begin
        any_ev = |strobe;
        take   = any_ev && !pending;
        drop   = (any_ev && pending) || (take && multi);
    end

    // Purpose: hold the winning event and its side information.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            cap_flags <= '0;
            cap_port  <= '0;
            cap_mac   <= '0;
            cap_db    <= '0;
            cap_pvec  <= '0;
        end else if (take) begin
            pending   <= 1'b1;
            cap_flags <= win;
            cap_port  <= in_port;
            cap_mac   <= in_mac;
            cap_db    <= in_db;
            cap_pvec  <= in_pvec;
        end else if (clr) begin
            pending   <= 1'b0;
        end
    end

    // Purpose: sticky overflow, restarted by a collect with this cycle's drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (clr) begin
            ovf <= drop;
        end else if (drop) begin
            ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/vcap_cmd.sv
// Module: command decode and report words for get-and-clear.
// Assumes software writes only while busy is low. Writes during busy are ignored.
module vcap_cmd
    import vcap_pkg::*;
#(
    parameter int NPORT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_wr,
    input  logic [15:0]       op_wdata,
    input  logic              pending,
    input  logic              ovf,
    input  logic [NKIND-1:0]  cap_flags,
    input  logic [PID_W-1:0]  cap_port,
    input  logic [47:0]       cap_mac,
    input  logic [DB_W-1:0]   cap_db,
    input  logic [NPORT-1:0]  cap_pvec,
    output logic              clr,
    output logic [15:0]       op_word,
    output logic [15:0]       data_word,
    output logic [47:0]       mac_word
);
    logic        busy_q;
    logic        accept;
    logic [14:0] op_q;
    logic [15:0] data_q;
    logic [47:0] mac_q;

    // Purpose: recognise a well-formed get-and-clear request.
    always_comb begin
        accept = op_wr && op_wdata[15] && (op_wdata[14:12] == OPC_GETCLR) && !busy_q;
        clr    = busy_q;
    end

    // Purpose: one-cycle busy window between request and report.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= accept;
    end

    // Purpose: load the report words when busy completes (zeros if nothing held).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            data_q <= '0;
            mac_q  <= '0;
        end else if (busy_q) begin
            op_q <= {OPC_GETCLR, ovf, 1'b0,
                     pending ? cap_db[DB_W-1:DB_LO_W] : {DB_HI_W{1'b0}},
                     pending ? cap_flags : {NKIND{1'b0}},
                     pending ? cap_db[DB_LO_W-1:0] : {DB_LO_W{1'b0}}};
            data_q <= pending ? ((16'(cap_pvec) << PID_W) | 16'(cap_port)) : 16'h0000;
            mac_q  <= pending ? cap_mac : 48'h0;
        end
    end

    assign op_word   = {busy_q, op_q};
    assign data_word = data_q;
    assign mac_word  = mac_q;
endmodule

// File: rtl/vcap_top.sv
// Module: address table violation capture, top level.
// Joins the capture holder and the command/report logic. NPORT must be 12 or less
// so that the port vector fits above the 4-bit port field of the data word.
module vcap_top
    import vcap_pkg::*;
#(
    parameter int NPORT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_full,
    input  logic             ev_miss,
    input  logic             ev_member,
    input  logic             ev_age,
    input  logic [3:0]       ev_port,
    input  logic [47:0]      ev_mac,
    input  logic [5:0]       ev_db,
    input  logic [NPORT-1:0] ev_pvec,
    input  logic             op_wr,
    input  logic [15:0]      op_wdata,
    output logic             irq,
    output logic [15:0]      op_rdata,
    output logic [15:0]      data_rdata,
    output logic [47:0]      mac_rdata
);
    logic [NKIND-1:0] ev_vec;
    logic             pending;
    logic             hold_ovf;
    logic             clr;
    logic [NKIND-1:0] cap_flags;
    logic [PID_W-1:0] cap_port;
    logic [47:0]      cap_mac;
    logic [DB_W-1:0]  cap_db;
    logic [NPORT-1:0] cap_pvec;

    // Purpose: arrange the strobes in priority order (index 0 wins).
    always_comb begin
        ev_vec         = '0;
        ev_vec[K_FULL]   = ev_full;
        ev_vec[K_MISS]   = ev_miss;
        ev_vec[K_MEMBER] = ev_member;
        ev_vec[K_AGE]    = ev_age;
    end

    vcap_hold #(.NPORT(NPORT)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (ev_vec),
        .in_port   (ev_port),
        .in_mac    (ev_mac),
        .in_db     (ev_db),
        .in_pvec   (ev_pvec),
        .clr       (clr),
        .pending   (pending),
        .ovf       (hold_ovf),
        .cap_flags (cap_flags),
        .cap_port  (cap_port),
        .cap_mac   (cap_mac),
        .cap_db    (cap_db),
        .cap_pvec  (cap_pvec)
    );

    vcap_cmd #(.NPORT(NPORT)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_wr     (op_wr),
        .op_wdata  (op_wdata),
        .pending   (pending),
        .ovf       (hold_ovf),
        .cap_flags (cap_flags),
        .cap_port  (cap_port),
        .cap_mac   (cap_mac),
        .cap_db    (cap_db),
        .cap_pvec  (cap_pvec),
        .clr       (clr),
        .op_word   (op_rdata),
        .data_word (data_rdata),
        .mac_word  (mac_rdata)
    );

    assign irq = pending;
endmodule

// File: rtl/vcap_chk.sv
// Module: protocol checker for vcap_top, attached with bind below.
// Checks timing relations between the interrupt, busy, the flags and overflow.
module vcap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  ev_vec,
    input logic        ovf,
    input logic        irq,
    input logic [15:0] op_rdata,
    input logic [15:0] data_rdata,
    input logic [47:0] mac_rdata
);
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_vec) && !irq) |=> irq);

    p_irq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !op_rdata[15]) |=> irq);

    p_no_overflow_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !op_rdata[15]) |=> ovf);

    p_flags_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_rdata[7:4]));

    p_busy_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_rdata[15] |=> !op_rdata[15]);

    p_empty_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_rdata[15] && !irq) |=> (op_rdata[7:4] == 4'h0));

    p_report_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_rdata[15] |=> ($stable(data_rdata) && $stable(mac_rdata) && $stable(op_rdata[14:0])));

    p_irq_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_rdata[15] && irq) |=> !irq);
endmodule

bind vcap_top vcap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_vec     (ev_vec),
    .ovf        (hold_ovf),
    .irq        (irq),
    .op_rdata   (op_rdata),
    .data_rdata (data_rdata),
    .mac_rdata  (mac_rdata)
);

// File: tb/sim_vcap_top.sv
`timescale 1ns/1ps
module sim_vcap_top;
    localparam int NPORT = 11;

    typedef struct packed {
        logic [3:0]       mask;   // bit0 full, bit1 miss, bit2 member, bit3 age
        logic [3:0]       port;
        logic [5:0]       db;
        logic [NPORT-1:0] pvec;
        logic [47:0]      mac;
        logic [3:0]       xflags; // expected flags (op bits 7:4)
        logic             xovf;   // expected overflow
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TAB [NV] = '{
        '{4'b0001, 4'd3,  6'h2A, 11'h005, 48'h0011_2233_4455, 4'b0001, 1'b0},
        '{4'b0010, 4'd9,  6'h15, 11'h7FF, 48'hAABB_CCDD_EEFF, 4'b0010, 1'b0},
        '{4'b0100, 4'd0,  6'h3F, 11'h400, 48'h0123_4567_89AB, 4'b0100, 1'b0},
        '{4'b1000, 4'd15, 6'h00, 11'h001, 48'hFFFF_FFFF_FFFF, 4'b1000, 1'b0},
        '{4'b1100, 4'd5,  6'h10, 11'h0F0, 48'h0200_0000_0001, 4'b0100, 1'b1},
        '{4'b1111, 4'd10, 6'h0F, 11'h2AA, 48'h5A5A_5A5A_5A5A, 4'b0001, 1'b1},
        '{4'b0110, 4'd1,  6'h31, 11'h155, 48'h0000_0000_0000, 4'b0010, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ev_full = 1'b0, ev_miss = 1'b0, ev_member = 1'b0, ev_age = 1'b0;
    logic [3:0]       ev_port = '0;
    logic [47:0]      ev_mac = '0;
    logic [5:0]       ev_db = '0;
    logic [NPORT-1:0] ev_pvec = '0;
    logic             op_wr = 1'b0;
    logic [15:0]      op_wdata = '0;
    logic             irq;
    logic [15:0]      op_rdata;
    logic [15:0]      data_rdata;
    logic [47:0]      mac_rdata;

    int nchk = 0;
    int nbad = 0;

    always #2.5 clk = ~clk;

    vcap_top #(.NPORT(NPORT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_full(ev_full), .ev_miss(ev_miss), .ev_member(ev_member), .ev_age(ev_age),
        .ev_port(ev_port), .ev_mac(ev_mac), .ev_db(ev_db), .ev_pvec(ev_pvec),
        .op_wr(op_wr), .op_wdata(op_wdata),
        .irq(irq), .op_rdata(op_rdata), .data_rdata(data_rdata), .mac_rdata(mac_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_op(input logic [5:0] db, input logic [3:0] fl, input logic ov);
        return {1'b0, 3'b111, ov, 1'b0, db[5:4], fl, db[3:0]};
    endfunction

    // Drive strobes for one clock edge, starting just after a falling edge.
    task automatic put_strobes(input logic [3:0] m);
        ev_full = m[0]; ev_miss = m[1]; ev_member = m[2]; ev_age = m[3];
    endtask

    task automatic fire(input vec_t v);
        put_strobes(v.mask);
        ev_port = v.port; ev_mac = v.mac; ev_db = v.db; ev_pvec = v.pvec;
        @(negedge clk);
        put_strobes(4'b0000);
    endtask

    // Get-and-clear: busy high one cycle, then report words loaded.
    task automatic getclr();
        op_wr = 1'b1; op_wdata = 16'hF000;
        @(negedge clk);
        op_wr = 1'b0; op_wdata = '0;
        chk("R5 busy set", 64'(op_rdata[15]), 64'd1);
        @(negedge clk);
        chk("R5 busy clear", 64'(op_rdata[15]), 64'd0);
    endtask

    initial begin : watchdog
        #1_000_000;
        nchk++; nbad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin : main
        logic [15:0] op_before;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 op", 64'(op_rdata), 64'd0);
        chk("R1 data", 64'(data_rdata), 64'd0);
        chk("R1 mac", 64'(mac_rdata), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R4, R5, R6, R7
        for (int i = 0; i < NV; i++) begin
            fire(TAB[i]);
            chk("R2 irq after capture", 64'(irq), 64'd1);
            @(negedge clk);
            chk("R2 irq held", 64'(irq), 64'd1);
            getclr();
            chk("R5 irq cleared", 64'(irq), 64'd0);
            chk("R4 R7 op word", 64'(op_rdata), 64'(exp_op(TAB[i].db, TAB[i].xflags, TAB[i].xovf)));
            chk("R6 data word", 64'(data_rdata), 64'((16'(TAB[i].pvec) << 4) | 16'(TAB[i].port)));
            chk("R6 mac word", 64'(mac_rdata), 64'(TAB[i].mac));
        end

        // R8 empty get-and-clear
        getclr();
        chk("R8 op empty", 64'(op_rdata), 64'(exp_op(6'h0, 4'h0, 1'b0)));
        chk("R8 data empty", 64'(data_rdata), 64'd0);
        chk("R8 mac empty", 64'(mac_rdata), 64'd0);
        chk("R8 irq low", 64'(irq), 64'd0);

        // R3 drop while held, sticky overflow, then cleared
        fire(TAB[0]);
        fire(TAB[1]);
        @(negedge clk);
        getclr();
        chk("R3 first kept", 64'(op_rdata), 64'(exp_op(TAB[0].db, 4'b0001, 1'b1)));
        chk("R3 first mac", 64'(mac_rdata), 64'(TAB[0].mac));
        chk("R3 irq after drop", 64'(irq), 64'd0);
        getclr();
        chk("R3 overflow cleared", 64'(op_rdata), 64'(exp_op(6'h0, 4'h0, 1'b0)));

        // R9 malformed writes ignored while held
        fire(TAB[2]);
        op_before = op_rdata;
        op_wr = 1'b1; op_wdata = 16'h7000;
        @(negedge clk);
        op_wdata = 16'hB000;
        @(negedge clk);
        op_wr = 1'b0; op_wdata = '0;
        chk("R9 busy low", 64'(op_rdata[15]), 64'd0);
        @(negedge clk);
        chk("R9 op unchanged", 64'(op_rdata), 64'(op_before));
        chk("R9 mac unchanged", 64'(mac_rdata), 64'd0);
        chk("R9 irq kept", 64'(irq), 64'd1);
        getclr();
        chk("R9 then collect", 64'(mac_rdata), 64'(TAB[2].mac));

        // R10 strobe during completion cycle is dropped
        fire(TAB[3]);
        op_wr = 1'b1; op_wdata = 16'hF000;
        @(negedge clk);
        op_wr = 1'b0; op_wdata = '0;
        ev_port = TAB[1].port; ev_mac = TAB[1].mac; ev_db = TAB[1].db; ev_pvec = TAB[1].pvec;
        put_strobes(4'b0010);
        @(negedge clk);
        put_strobes(4'b0000);
        chk("R10 irq low", 64'(irq), 64'd0);
        chk("R10 report old", 64'(op_rdata), 64'(exp_op(TAB[3].db, 4'b1000, 1'b0)));
        getclr();
        chk("R10 overflow only", 64'(op_rdata), 64'(exp_op(6'h0, 4'h0, 1'b1)));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule